// File: doc/BRIEF.md
# Triple interval timer counter

This block holds three independent up-counting timer channels behind one register map. A channel takes the system clock, can divide it by a power of two, and advances its counter on each divided tick. The counter either runs freely and wraps at its top value, or runs in interval mode, where it counts from zero up to a programmed limit and then reloads. Each channel flags wraps and interval hits in a status register. Reading that register hands the flags to software and clears them in the same access. A per-channel interrupt line is raised while an enabled flag is pending.

Software drives the block over a plain 32-bit register port. A request is one cycle of `bus_en` with `bus_we` choosing a write or a read. The port applies no back-pressure, so every request is taken in the cycle it is presented. Read data comes back with a one-cycle `bus_rvalid` strobe. The interrupt outputs are plain level signals.

Top module: `triple_interval_timer`

## Requirements
- R1: After reset, every channel reads clock control 0x00, counter control 0x01 (stopped), count 0, interval all ones (0xFFFF at 16 bits), status 0 and enable 0, and every interrupt output is low.
- R2: The register banks sit at clock control 0x00, counter control 0x0C, count 0x18, interval 0x24, status 0x54 and enable 0x60. Channel n uses bank base + 4*n. A read of any other address returns 0.
- R3: In clock control, bit 0 enables the prescaler, bits 4:1 hold the exponent P and bit 5 is a stored source-select flag. All six bits read back as written, and the higher bits read 0.
- R4: With the prescaler enabled the counter advances once every 2^(P+1) clocks. With it disabled the counter advances on every clock while running.
- R5: Counter control bit 0 set to 1 stops the counter and holds its value. Clearing the bit resumes counting from the held value.
- R6: Writing 1 to counter control bit 4 restarts the count and the prescaler phase from zero. The bit is not stored and reads back 0, while bits 0 and 1 read back as written.
- R7: In free-running mode (counter control bit 1 = 0) the counter wraps from all ones to 0, and the wrap sets status bit 4.
- R8: In interval mode (counter control bit 1 = 1), a tick taken while the count equals the interval value reloads the count to 0 and sets status bit 0. The count therefore cycles through interval+1 values.
- R9: A status read returns the pending flags and clears them. A flag raised in the same cycle as the read is kept.
- R10: The enable register stores only bits 0 and 4, and reads them back at those positions. A channel's interrupt output is high exactly when a status bit and its enable bit are both set.
- R11: The count register returns the live count: a read captures the count held just before its request edge.
- R12: Every read request is answered by `bus_rdata` with `bus_rvalid` high in the following cycle, and `bus_rvalid` is low in all other cycles.
- R13: Writes and counting on one channel leave the registers of the other channels unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for the whole block |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Register request this cycle, always accepted |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (8) | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read response strobe, one cycle after a read request |
| irq | output | NUM_CH (3) | Per-channel interrupt level |

## Verification
A register write takes effect at the clock edge that accepts it, and the count moves on the following ticks. When a counter control write starts a channel at edge E and a second write stops it K+1 edges later, the channel receives exactly K+1 prescaler clocks, so the expected count is floor((K+1)/2^(P+1)). In interval mode the count is that tick number modulo interval+1. The bench stops a channel before it reads the count back, so the sampling instant cannot change the result. Read data and status clearing are due one cycle after the request, and the interrupt level is sampled on the falling edge that follows the stop or the status read. The live-count check relies on back-to-back reads returning consecutive values.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int BANKS = 6;
  localparam int STS_W = 5;

  // bank indices used for decode and read muxing
  localparam int BK_CLK  = 0;
  localparam int BK_CNT  = 1;
  localparam int BK_VAL  = 2;
  localparam int BK_INTV = 3;
  localparam int BK_STS  = 4;
  localparam int BK_IEN  = 5;

  // field positions
  localparam int CC_PRE_EN  = 0;
  localparam int CC_EXP_LSB = 1;
  localparam int CC_SRC     = 5;
  localparam int CT_STOP    = 0;
  localparam int CT_MODE    = 1;
  localparam int CT_RESTART = 4;
  localparam int ST_INTV    = 0;
  localparam int ST_OVF     = 4;

  function automatic int unsigned bank_base(input int unsigned b);
    case (b)
      0:       return 32'h00;
      1:       return 32'h0C;
      2:       return 32'h18;
      3:       return 32'h24;
      4:       return 32'h54;
      default: return 32'h60;
    endcase
  endfunction
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int EXP_W = 4,
  localparam int DIV_W = 1 << EXP_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             en,
  input  logic [EXP_W-1:0] exp_sel,
  input  logic             clr,
  output logic             tick
);
  logic [DIV_W-1:0] div_q;
  logic [DIV_W:0]   lim_w;
  logic             at_lim;

  // divide ratio is 2^(exp_sel+1); terminal count is that minus one
  assign lim_w  = ((DIV_W+1)'(1) << ({1'b0, exp_sel} + 1'b1)) - (DIV_W+1)'(1);
  assign at_lim = (div_q == lim_w[DIV_W-1:0]);
  assign tick   = run && (!en || at_lim);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      div_q <= '0;
    end else if (run && en) begin
      div_q <= at_lim ? '0 : div_q + 1'b1;
    end
  end
endmodule

// File: rtl/tmr_decode.sv
module tmr_decode
  import tmr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NUM_CH = 3
) (
  input  logic [ADDR_W-1:0]             addr,
  output logic [NUM_CH-1:0][BANKS-1:0]  hit
);
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    for (genvar b = 0; b < BANKS; b++) begin : g_bank
      assign hit[ch][b] = (addr == ADDR_W'(bank_base(b) + 4 * ch));
    end
  end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int EXP_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_clk,
  input  logic             wr_cnt,
  input  logic             wr_intv,
  input  logic             wr_ien,
  input  logic             rd_sts,
  input  logic [31:0]      wdata,
  output logic [31:0]      rd_vals [BANKS],
  output logic             irq,
  output logic [CNT_W-1:0] cnt_o,
  output logic             stop_o,
  output logic             pre_en_o,
  output logic [STS_W-1:0] sts_o
);
  logic             pre_en_q, src_q, stop_q, mode_q;
  logic [EXP_W-1:0] exp_q;
  logic [CNT_W-1:0] cnt_q, intv_q;
  logic [STS_W-1:0] sts_q, ien_q;
  logic             restart, tick, hit_intv, hit_max;
  logic [STS_W-1:0] events;

  assign restart  = wr_cnt && wdata[CT_RESTART];
  assign hit_intv = mode_q && (cnt_q == intv_q);
  assign hit_max  = (cnt_q == {CNT_W{1'b1}});

  tmr_prescaler #(.EXP_W(EXP_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (!stop_q),
    .en      (pre_en_q),
    .exp_sel (exp_q),
    .clr     (restart || wr_clk),
    .tick    (tick)
  );

  always_comb begin
    events = '0;
    if (tick && !restart) begin
      events[ST_INTV] = hit_intv;
      events[ST_OVF]  = !hit_intv && hit_max;
    end
  end

  // configuration registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_en_q <= 1'b0;
      exp_q    <= '0;
      src_q    <= 1'b0;
      stop_q   <= 1'b1;
      mode_q   <= 1'b0;
      intv_q   <= '1;
      ien_q    <= '0;
    end else begin
      if (wr_clk) begin
        pre_en_q <= wdata[CC_PRE_EN];
        exp_q    <= wdata[CC_EXP_LSB +: EXP_W];
        src_q    <= wdata[CC_SRC];
      end
      if (wr_cnt) begin
        stop_q <= wdata[CT_STOP];
        mode_q <= wdata[CT_MODE];
      end
      if (wr_intv) intv_q <= wdata[CNT_W-1:0];
      if (wr_ien) begin
        ien_q[ST_INTV] <= wdata[ST_INTV];
        ien_q[ST_OVF]  <= wdata[ST_OVF];
      end
    end
  end

  // counter and status
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sts_q <= '0;
    end else begin
      if (restart) begin
        cnt_q <= '0;
      end else if (tick) begin
        cnt_q <= hit_intv ? '0 : cnt_q + 1'b1;
      end
      sts_q <= (rd_sts ? '0 : sts_q) | events;
    end
  end

  assign irq = |(sts_q & ien_q);

  always_comb begin
    rd_vals[BK_CLK]  = 32'({src_q, exp_q, pre_en_q});
    rd_vals[BK_CNT]  = 32'({mode_q, stop_q});
    rd_vals[BK_VAL]  = 32'(cnt_q);
    rd_vals[BK_INTV] = 32'(intv_q);
    rd_vals[BK_STS]  = 32'(sts_q);
    rd_vals[BK_IEN]  = 32'(ien_q);
  end

  assign cnt_o    = cnt_q;
  assign stop_o   = stop_q;
  assign pre_en_o = pre_en_q;
  assign sts_o    = sts_q;
endmodule

// File: rtl/triple_interval_timer.sv
module triple_interval_timer
  import tmr_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  output logic [NUM_CH-1:0] irq
);
  localparam int EXP_W = 4;

  logic [NUM_CH-1:0][BANKS-1:0] hit;
  logic [31:0]                  rd_vals [NUM_CH][BANKS];
  logic [31:0]                  rd_mux;
  logic                         wr_req, rd_req;
  logic [NUM_CH-1:0]            cnt_wr, sts_rd, stop_all, pre_en_all;
  logic [NUM_CH-1:0][CNT_W-1:0] cnt_all;
  logic [NUM_CH-1:0][STS_W-1:0] sts_all;

  assign wr_req = bus_en && bus_we;
  assign rd_req = bus_en && !bus_we;

  tmr_decode #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH)) u_dec (
    .addr (bus_addr),
    .hit  (hit)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    assign cnt_wr[ch] = wr_req && hit[ch][BK_CNT];
    assign sts_rd[ch] = rd_req && hit[ch][BK_STS];

    tmr_channel #(.CNT_W(CNT_W), .EXP_W(EXP_W)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_clk   (wr_req && hit[ch][BK_CLK]),
      .wr_cnt   (cnt_wr[ch]),
      .wr_intv  (wr_req && hit[ch][BK_INTV]),
      .wr_ien   (wr_req && hit[ch][BK_IEN]),
      .rd_sts   (sts_rd[ch]),
      .wdata    (bus_wdata),
      .rd_vals  (rd_vals[ch]),
      .irq      (irq[ch]),
      .cnt_o    (cnt_all[ch]),
      .stop_o   (stop_all[ch]),
      .pre_en_o (pre_en_all[ch]),
      .sts_o    (sts_all[ch])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int ch = 0; ch < NUM_CH; ch++) begin
      for (int b = 0; b < BANKS; b++) begin
        if (hit[ch][b]) rd_mux = rd_mux | rd_vals[ch][b];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= rd_req;
      if (rd_req) bus_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
  import tmr_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 8
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         bus_en,
  input logic                         bus_we,
  input logic [ADDR_W-1:0]            bus_addr,
  input logic [31:0]                  bus_wdata,
  input logic [31:0]                  bus_rdata,
  input logic                         bus_rvalid,
  input logic [NUM_CH-1:0]            irq,
  input logic [NUM_CH-1:0]            cnt_wr,
  input logic [NUM_CH-1:0]            sts_rd,
  input logic [NUM_CH-1:0]            stop_all,
  input logic [NUM_CH-1:0]            pre_en_all,
  input logic [NUM_CH-1:0][CNT_W-1:0] cnt_all,
  input logic [NUM_CH-1:0][STS_W-1:0] sts_all
);
  function automatic logic is_mapped(input logic [ADDR_W-1:0] a);
    logic m;
    m = 1'b0;
    for (int b = 0; b < BANKS; b++) begin
      if (int'(a) >= bank_base(b) && int'(a) < bank_base(b) + 4 * NUM_CH &&
          a[1:0] == 2'b00)
        m = 1'b1;
    end
    return m;
  endfunction

  AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_we) |=> bus_rvalid); // R12
  AST_RVALID_ONLY_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_en && !bus_we) |=> !bus_rvalid); // R12
  AST_UNMAPPED_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_we && !is_mapped(bus_addr)) |=> (bus_rdata == 32'd0)); // R2

  for (genvar n = 0; n < NUM_CH; n++) begin : g_chk
    AST_STOP_HOLDS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_all[n] && !cnt_wr[n]) |=> $stable(cnt_all[n])); // R5
    AST_RESTART_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_wr[n] && bus_wdata[CT_RESTART]) |=> (cnt_all[n] == '0)); // R6
    AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (!stop_all[n] && !pre_en_all[n] && !cnt_wr[n]) |=>
        (cnt_all[n] == $past(cnt_all[n]) + 1'b1 || cnt_all[n] == '0)); // R4
    AST_READ_CLEARS_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_rd[n] && stop_all[n]) |=> (sts_all[n] == '0)); // R9
    AST_IRQ_LOW_AFTER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_rd[n] && stop_all[n]) |=> !irq[n]); // R10
  end
endmodule

bind triple_interval_timer tmr_checker #(
  .NUM_CH (NUM_CH),
  .CNT_W  (CNT_W),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_en     (bus_en),
  .bus_we     (bus_we),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .bus_rvalid (bus_rvalid),
  .irq        (irq),
  .cnt_wr     (cnt_wr),
  .sts_rd     (sts_rd),
  .stop_all   (stop_all),
  .pre_en_all (pre_en_all),
  .cnt_all    (cnt_all),
  .sts_all    (sts_all)
);

// File: tb/triple_interval_timer_test.sv
module triple_interval_timer_test;
  localparam int NCH = 3;
  localparam int AW  = 8;
  localparam int A_CLK = 'h00, A_CNT = 'h0C, A_VAL = 'h18;
  localparam int A_INTV = 'h24, A_STS = 'h54, A_IEN = 'h60;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_en = 1'b0, bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          bus_rvalid;
  logic [NCH-1:0] irq;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  triple_interval_timer #(.NUM_CH(NCH), .CNT_W(16), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .irq(irq)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] ra(input int base, input int ch);
    return AW'(base + 4 * ch);
  endfunction

  // drive at the falling edge, accepted at the next rising edge
  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(posedge clk);
    @(negedge clk);
    bus_en = 1'b0;
    chk(32'(bus_rvalid), 32'd1, "R12 rvalid");
    d = bus_rdata;
  endtask

  task automatic idle(input int k);
    repeat (k) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, v2, held;
    int k, t, ex;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(32'(irq), 0, "R1 irq");
    chk(32'(bus_rvalid), 0, "R12 idle rvalid");
    for (int ch = 0; ch < NCH; ch++) begin
      rd(ra(A_CLK, ch), v);  chk(v, 32'h0, "R1 clk ctrl");
      rd(ra(A_CNT, ch), v);  chk(v, 32'h1, "R1 cnt ctrl");
      rd(ra(A_VAL, ch), v);  chk(v, 32'h0, "R1 count");
      rd(ra(A_INTV, ch), v); chk(v, 32'hFFFF, "R1 interval");
      rd(ra(A_STS, ch), v);  chk(v, 32'h0, "R1 status");
      rd(ra(A_IEN, ch), v);  chk(v, 32'h0, "R1 enable");
    end

    // R2 unmapped addresses
    rd(8'h30, v); chk(v, 0, "R2 unmapped 0x30");
    rd(8'h50, v); chk(v, 0, "R2 unmapped 0x50");
    rd(8'h6C, v); chk(v, 0, "R2 unmapped 0x6C");
    rd(8'h26, v); chk(v, 0, "R2 unaligned 0x26");

    // R3 clock control readback
    wr(ra(A_CLK, 1), 32'hFFFF_FFFF); rd(ra(A_CLK, 1), v); chk(v, 32'h3F, "R3 all ones");
    wr(ra(A_CLK, 2), 32'h2A);        rd(ra(A_CLK, 2), v); chk(v, 32'h2A, "R3 pattern");
    rd(ra(A_CLK, 0), v); chk(v, 0, "R13 neighbour clk ctrl");
    wr(ra(A_CLK, 1), 0); wr(ra(A_CLK, 2), 0);

    // R6 restart bit not stored
    wr(ra(A_CNT, 0), 32'h12); rd(ra(A_CNT, 0), v); chk(v, 32'h2, "R6 restart reads 0");
    wr(ra(A_CNT, 0), 32'h11);
    rd(ra(A_VAL, 0), v); chk(v, 0, "R6 count zero after restart");

    // R4 prescale sweep per channel
    for (int ch = 0; ch < NCH; ch++) begin
      for (int p = -1; p < 4; p++) begin
        k = 37 + ch * 5 + (p + 1) * 11;
        wr(ra(A_CLK, ch), (p < 0) ? 32'h0 : 32'((p << 1) | 1));
        wr(ra(A_CNT, ch), 32'h10);
        idle(k);
        wr(ra(A_CNT, ch), 32'h01);
        ex = (p < 0) ? (k + 1) : ((k + 1) >> (p + 1));
        rd(ra(A_VAL, ch), v);
        chk(v, 32'(ex), $sformatf("R4 ch%0d exp %0d", ch, p));
      end
      if (ch == 0) begin
        rd(ra(A_VAL, 1), v); chk(v, 0, "R13 ch1 untouched");
        rd(ra(A_VAL, 2), v); chk(v, 0, "R13 ch2 untouched");
      end
    end

    // R5 stop holds, resume continues
    rd(ra(A_VAL, 1), held);
    idle(25);
    rd(ra(A_VAL, 1), v); chk(v, held, "R5 hold while stopped");
    wr(ra(A_CLK, 1), 0);
    wr(ra(A_CNT, 1), 32'h00);
    idle(19);
    wr(ra(A_CNT, 1), 32'h01);
    rd(ra(A_VAL, 1), v); chk(v, held + 20, "R5 resume from held");

    // R11 live count
    wr(ra(A_CLK, 2), 0);
    wr(ra(A_CNT, 2), 32'h10);
    rd(ra(A_VAL, 2), v);
    rd(ra(A_VAL, 2), v2);
    chk(v, 0, "R11 first live read");
    chk(v2, 1, "R11 second live read");
    wr(ra(A_CNT, 2), 32'h01);

    // R8 R9 R10 interval mode sweep on channel 0
    wr(ra(A_CLK, 0), 0);
    wr(ra(A_IEN, 0), 32'hFFFF_FFFF);
    rd(ra(A_IEN, 0), v); chk(v, 32'h11, "R10 enable bits stored");
    wr(ra(A_IEN, 0), 32'h1);
    rd(ra(A_STS, 0), v);
    for (int i = 0; i < 6; i++) begin
      for (int s = 0; s < 2; s++) begin
        k = (s == 0) ? i * 3 + 4 : ((i > 0) ? i - 1 : 2);
        t = k + 1;
        wr(ra(A_INTV, 0), 32'(i));
        wr(ra(A_CNT, 0), 32'h12);
        idle(k);
        wr(ra(A_CNT, 0), 32'h03);
        chk(32'(irq[0]), (t >= i + 1) ? 1 : 0, $sformatf("R10 irq intv %0d", i));
        chk(32'(irq[2:1]), 0, "R13 other irqs low");
        rd(ra(A_VAL, 0), v); chk(v, 32'(t % (i + 1)), $sformatf("R8 count intv %0d", i));
        rd(ra(A_STS, 0), v); chk(v, (t >= i + 1) ? 1 : 0, $sformatf("R8 status intv %0d", i));
        chk(32'(irq[0]), 0, "R10 irq after status read");
        rd(ra(A_STS, 0), v); chk(v, 0, "R9 status cleared by read");
      end
    end

    // R7 free-running wrap on channel 1
    wr(ra(A_IEN, 1), 32'h10);
    wr(ra(A_CNT, 1), 32'h10);
    idle(65536 + 2);
    wr(ra(A_CNT, 1), 32'h01);
    chk(32'(irq[1]), 1, "R7 overflow irq");
    rd(ra(A_VAL, 1), v); chk(v, 3, "R7 count after wrap");
    rd(ra(A_STS, 1), v); chk(v, 32'h10, "R7 overflow flag");
    rd(ra(A_STS, 1), v); chk(v, 0, "R9 overflow cleared");
    chk(32'(irq[1]), 0, "R10 irq cleared");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule